// File: doc/BRIEF.md
# Sequential Fixed-Point Divider

This block divides one signed fixed-point number by another. Both operands and the result share one format: a word of N bits in two's complement, of which the lowest Q bits are fraction. A one-cycle start strobe captures the operands. The block then computes the magnitude of the quotient one bit per clock with a compare-and-subtract loop. It signals completion with a one-cycle done strobe after a fixed number of cycles that never depends on the operand values.

The magnitude loop never shifts the partial remainder. Instead, the dividend magnitude is loaded pre-scaled by 2^Q into a remainder register N+Q-1 bits wide. The divisor magnitude is loaded into the top of a register 2*(N-1)+Q bits wide and moves one place toward the LSB every cycle. This is what produces the Q fraction bits of the quotient. The quotient sign is the exclusive OR of the operand sign bits. An overflow flag is raised when the magnitude does not fit in N-1 bits, and the output then saturates. A zero divisor is reported on its own flag and is also treated as an overflow.

Top module: `fxp_seq_divider`

## Requirements
- R1: After reset, busy, done, overflow and div_zero are 0 and quotient is all zeros.
- R2: A start that is sampled while idle is the first clock edge of an operation. On the (N+Q)-th edge counted from that one, done rises for exactly one cycle. busy is 1 from the first edge until done rises, for every operand pair.
- R3: For a nonzero divisor, the quotient magnitude equals floor(|dividend| * 2^Q / |divisor|) when that value is at most 2^(N-1)-1. It is a Q-fraction-bit value truncated toward zero.
- R4: The quotient sign is dividend[N-1] XOR divisor[N-1]. A negative result appears on quotient in two's complement, and a zero magnitude always gives an all-zero quotient.
- R5: When the magnitude in R3 exceeds 2^(N-1)-1, overflow is 1 and the magnitude saturates to 2^(N-1)-1, keeping the R4 sign. Otherwise overflow is 0.
- R6: When the divisor is zero, div_zero and overflow are both 1 and the magnitude saturates to 2^(N-1)-1, keeping the R4 sign.
- R7: A start asserted while busy is 1 is ignored. The running operation completes on its original schedule with its original operands.
- R8: An operand equal to -2^(N-1) is taken as magnitude 2^(N-1)-1.
- R9: quotient, overflow and div_zero change only on the edge that raises done, and they hold their values until the next such edge.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that captures the operands when idle |
| dividend | input | N | Signed fixed-point numerator, Q fraction bits |
| divisor | input | N | Signed fixed-point denominator, Q fraction bits |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle strobe: a new result is on the outputs |
| quotient | output | N | Signed fixed-point result, Q fraction bits |
| overflow | output | 1 | Result magnitude saturated (includes zero divisor) |
| div_zero | output | 1 | The divisor of the last operation was zero |

## Verification
The bench drives two instances. One has four fraction bits and one is integer only. Hand-worked integer and fractional divisions distinguish a correct bit-weight alignment from a divisor register that is off by one position. Non-terminating fractions such as one third separate truncation toward zero from rounding. The same pair applied under all four sign combinations exposes sign and two's-complement faults that positive-only data hides. Large quotients, zero divisors and the most negative operand test the saturation paths. A start pulsed mid-operation and results watched for several idle cycles separate a correctly gated controller from one that restarts or leaks intermediate values. Every operation is also timed edge by edge, so a latency that is off by one cycle or depends on the data is reported.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;

    // Controller phases of the divider.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    // Number of compare-and-subtract steps after the load cycle.
    function automatic int unsigned div_steps(input int unsigned n, input int unsigned q);
        return n + q - 1;
    endfunction

    // Width of a counter able to hold the value div_steps().
    function automatic int unsigned div_cnt_width(input int unsigned n, input int unsigned q);
        int unsigned w;
        w = $clog2(div_steps(n, q) + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/fxdiv_unsign.sv
// Splits a two's complement operand into sign and an (N-1)-bit magnitude.
// The most negative code has no (N-1)-bit magnitude and is clamped.
module fxdiv_unsign #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] op,
    output logic         neg,
    output logic [N-2:0] mag
);
    logic [N-1:0] inv;

    always_comb begin
        neg = op[N-1];
        inv = {N{1'b0}} - op;
        if (!neg) begin
            mag = op[N-2:0];
        end else if (inv[N-1]) begin
            mag = {(N-1){1'b1}};
        end else begin
            mag = inv[N-2:0];
        end
    end
endmodule

// File: rtl/fxdiv_stage.sv
// One restoring compare-and-subtract step with a right-moving divisor.
module fxdiv_stage #(
    parameter int unsigned RW = 23,
    parameter int unsigned DW = 38,
    parameter int unsigned QW = 23,
    parameter int unsigned CW = 5
) (
    input  logic [RW-1:0] rem,
    input  logic [DW-1:0] dsr,
    input  logic [QW-1:0] quo,
    input  logic [CW-1:0] bit_idx,
    output logic [RW-1:0] rem_nxt,
    output logic [DW-1:0] dsr_nxt,
    output logic [QW-1:0] quo_nxt
);
    logic [DW-1:0] rem_wide;
    logic          take;

    always_comb begin
        rem_wide = DW'(rem);
        take     = !(dsr > rem_wide);
        rem_nxt  = take ? (rem - dsr[RW-1:0]) : rem;
        dsr_nxt  = dsr >> 1;
        for (int i = 0; i < int'(QW); i++) begin
            quo_nxt[i] = quo[i] | (take && (bit_idx == CW'(i)));
        end
    end
endmodule

// File: rtl/fxdiv_pack.sv
// Turns sign, raw quotient magnitude and zero-divisor status into the
// saturated two's complement result and the overflow flag.
module fxdiv_pack #(
    parameter int unsigned N  = 16,
    parameter int unsigned QW = 23
) (
    input  logic          neg,
    input  logic          dz,
    input  logic [QW-1:0] quo,
    output logic [N-1:0]  res,
    output logic          ovf
);
    logic         too_big;
    logic [N-2:0] mag;

    generate
        if (QW > N - 1) begin : g_upper
            assign too_big = |quo[QW-1:N-1];
        end else begin : g_none
            assign too_big = 1'b0;
        end
    endgenerate

    always_comb begin
        ovf = dz | too_big;
        mag = ovf ? {(N-1){1'b1}} : quo[N-2:0];
        res = neg ? (N'(0) - {1'b0, mag}) : {1'b0, mag};
    end
endmodule

// File: rtl/fxp_seq_divider.sv
module fxp_seq_divider
    import fxdiv_pkg::*;
#(
    parameter int unsigned N = 16,
    parameter int unsigned Q = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] quotient,
    output logic         overflow,
    output logic         div_zero
);
    localparam int unsigned RW    = N + Q - 1;
    localparam int unsigned DW    = 2 * (N - 1) + Q;
    localparam int unsigned QW    = N + Q - 1;
    localparam int unsigned STEPS = div_steps(N, Q);
    localparam int unsigned CW    = div_cnt_width(N, Q);

    div_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] rem_q;
    logic [DW-1:0] dsr_q;
    logic [QW-1:0] quo_q;
    logic          neg_q;
    logic          dz_q;

    logic          neg_a, neg_b;
    logic [N-2:0]  mag_a, mag_b;
    logic [RW-1:0] rem_nxt;
    logic [DW-1:0] dsr_nxt;
    logic [QW-1:0] quo_nxt;
    logic [CW-1:0] bit_idx;
    logic [N-1:0]  res_w;
    logic          ovf_w;

    fxdiv_unsign #(.N(N)) u_abs_num (.op(dividend), .neg(neg_a), .mag(mag_a));
    fxdiv_unsign #(.N(N)) u_abs_den (.op(divisor),  .neg(neg_b), .mag(mag_b));

    assign bit_idx = cnt_q - CW'(1);

    fxdiv_stage #(.RW(RW), .DW(DW), .QW(QW), .CW(CW)) u_step (
        .rem(rem_q), .dsr(dsr_q), .quo(quo_q), .bit_idx(bit_idx),
        .rem_nxt(rem_nxt), .dsr_nxt(dsr_nxt), .quo_nxt(quo_nxt)
    );

    fxdiv_pack #(.N(N), .QW(QW)) u_pack (
        .neg(neg_q), .dz(dz_q), .quo(quo_nxt), .res(res_w), .ovf(ovf_w)
    );

    assign busy = (state_q == DIV_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= DIV_IDLE;
            cnt_q    <= '0;
            rem_q    <= '0;
            dsr_q    <= '0;
            quo_q    <= '0;
            neg_q    <= 1'b0;
            dz_q     <= 1'b0;
            done     <= 1'b0;
            quotient <= '0;
            overflow <= 1'b0;
            div_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                DIV_IDLE: begin
                    if (start) begin
                        // Top quotient bit is never set for a nonzero divisor,
                        // so the divisor is loaded already moved by one place.
                        rem_q   <= RW'(mag_a) << Q;
                        dsr_q   <= DW'(mag_b) << (N + Q - 2);
                        quo_q   <= '0;
                        neg_q   <= neg_a ^ neg_b;
                        dz_q    <= (mag_b == '0);
                        cnt_q   <= CW'(STEPS);
                        state_q <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    rem_q <= rem_nxt;
                    dsr_q <= dsr_nxt;
                    quo_q <= quo_nxt;
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) begin
                        quotient <= res_w;
                        overflow <= ovf_w;
                        div_zero <= dz_q;
                        done     <= 1'b1;
                        state_q  <= DIV_IDLE;
                    end
                end
                default: state_q <= DIV_IDLE;
            endcase
        end
    end

    // R2: completion strobe lasts one cycle and closes the busy window.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_busy_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3: the partial remainder never grows during an operation.
    assert_rem_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> (rem_q <= $past(rem_q)));

    // R5: an overflowed result is the saturated magnitude with either sign.
    assert_sat_value_R5: assert property (@(posedge clk) disable iff (rst)
        (done && overflow) |->
            ((quotient == {1'b0, {(N-1){1'b1}}}) ||
             (quotient == (N'(0) - {1'b0, {(N-1){1'b1}}}))));

    // R6: a zero divisor is always reported as an overflow as well.
    assert_dz_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> overflow);

    // R7: a start during an operation leaves the captured operand state alone.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(neg_q) && $stable(dz_q)));

    // R9: result outputs move only together with the done strobe.
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(overflow) && $stable(div_zero)));

endmodule

// File: tb/tb_fxp_seq_divider.sv
module tb_fxp_seq_divider;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 8;
    localparam int QA = 4;
    localparam int NB = 7;
    localparam int QB = 0;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic          st_a = 1'b0;
    logic [NA-1:0] num_a = '0, den_a = '0;
    logic          busy_a, done_a, ovf_a, dz_a;
    logic [NA-1:0] quo_a;

    logic          st_b = 1'b0;
    logic [NB-1:0] num_b = '0, den_b = '0;
    logic          busy_b, done_b, ovf_b, dz_b;
    logic [NB-1:0] quo_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxp_seq_divider #(.N(NA), .Q(QA)) dut (
        .clk(clk), .rst(rst), .start(st_a), .dividend(num_a), .divisor(den_a),
        .busy(busy_a), .done(done_a), .quotient(quo_a), .overflow(ovf_a), .div_zero(dz_a));

    fxp_seq_divider #(.N(NB), .Q(QB)) dut_int (
        .clk(clk), .rst(rst), .start(st_b), .dividend(num_b), .divisor(den_b),
        .busy(busy_b), .done(done_b), .quotient(quo_b), .overflow(ovf_b), .div_zero(dz_b));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent model of R3..R6 and R8.
    task automatic model(input int n, input int q, input longint a, input longint b,
                         output longint res, output bit ov, output bit dz);
        longint maxm, ma, mb, m;
        bit sa, sb;
        maxm = (longint'(1) << (n - 1)) - 1;
        sa = a[n-1];
        sb = b[n-1];
        ma = sa ? ((longint'(1) << n) - a) : a;
        mb = sb ? ((longint'(1) << n) - b) : b;
        if (ma > maxm) ma = maxm;
        if (mb > maxm) mb = maxm;
        dz = (mb == 0);
        if (dz) begin
            m = maxm; ov = 1'b1;
        end else begin
            m = (ma << q) / mb;
            ov = (m > maxm);
            if (ov) m = maxm;
        end
        res = (sa ^ sb) ? (((longint'(1) << n) - m) & ((longint'(1) << n) - 1)) : m;
    endtask

    task automatic run_a(input logic [NA-1:0] a, input logic [NA-1:0] b,
                         input string req, input bit poke);
        longint er; bit eo, ed;
        model(NA, QA, a, b, er, eo, ed);
        @(negedge clk);
        num_a = a; den_a = b; st_a = 1'b1;
        @(negedge clk);
        st_a = 1'b0;
        check(busy_a == 1'b1, "R2 busy after start", busy_a, 1);
        for (int k = 0; k < NA + QA - 2; k++) begin
            if (poke && k == 0) begin
                num_a = ~a; den_a = 8'h01; st_a = 1'b1;
            end
            @(negedge clk);
            st_a = 1'b0;
        end
        check(done_a == 1'b0, "R2 done not early", done_a, 0);
        @(negedge clk);
        check(done_a == 1'b1 && busy_a == 1'b0, "R2 done at N+Q edges", done_a, 1);
        check(quo_a == er[NA-1:0], req, quo_a, er);
        check(ovf_a == eo, {req, " overflow R5"}, ovf_a, eo);
        check(dz_a == ed, {req, " div_zero R6"}, dz_a, ed);
        @(negedge clk);
        check(done_a == 1'b0, "R2 done one cycle", done_a, 0);
    endtask

    task automatic run_b(input logic [NB-1:0] a, input logic [NB-1:0] b, input string req);
        longint er; bit eo, ed;
        model(NB, QB, a, b, er, eo, ed);
        @(negedge clk);
        num_b = a; den_b = b; st_b = 1'b1;
        @(negedge clk);
        st_b = 1'b0;
        for (int k = 0; k < NB + QB - 2; k++) @(negedge clk);
        check(done_b == 1'b0, "R2 integer done not early", done_b, 0);
        @(negedge clk);
        check(done_b == 1'b1, "R2 integer done", done_b, 1);
        check(quo_b == er[NB-1:0], req, quo_b, er);
        check(ovf_b == eo, {req, " overflow R5"}, ovf_b, eo);
    endtask

    task automatic t_reset();
        check(busy_a == 0 && done_a == 0 && ovf_a == 0 && dz_a == 0, "R1 flags", busy_a, 0);
        check(quo_a == '0, "R1 quotient", quo_a, 0);
    endtask

    task automatic t_examples();
        run_a(8'h13, 8'h04, "R3 1.0011b/0.01b", 1'b0);
        check(quo_a == 8'h4C, "R3 worked value 100.1100b", quo_a, 8'h4C);
        run_b(7'd54, 7'd5, "R3 integer 54/5");
        check(quo_b == 7'd10, "R3 integer value 10", quo_b, 10);
        run_b(7'd63, 7'd1, "R3 integer max");
    endtask

    task automatic t_signs();
        run_a(8'h13, 8'hFC, "R4 pos/neg", 1'b0);
        run_a(8'hED, 8'h04, "R4 neg/pos", 1'b0);
        run_a(8'hED, 8'hFC, "R4 neg/neg", 1'b0);
        run_a(8'h00, 8'hF0, "R4 zero result neg divisor", 1'b0);
    endtask

    task automatic t_trunc();
        run_a(8'h10, 8'h30, "R3 one third truncated", 1'b0);
        check(quo_a == 8'h05, "R3 one third value", quo_a, 5);
        run_a(8'hF0, 8'h30, "R4 minus one third toward zero", 1'b0);
        check(quo_a == 8'hFB, "R4 minus one third value", quo_a, 8'hFB);
    endtask

    task automatic t_overflow();
        run_a(8'h70, 8'h01, "R5 large quotient", 1'b0);
        run_a(8'h70, 8'hFF, "R5 large negative quotient", 1'b0);
        run_a(8'h08, 8'h01, "R5 exact limit 127", 1'b0);
        run_b(7'd40, 7'd0, "R6 integer zero divisor");
    endtask

    task automatic t_zero();
        run_a(8'h25, 8'h00, "R6 zero divisor", 1'b0);
        run_a(8'hC0, 8'h00, "R6 zero divisor negative", 1'b0);
    endtask

    task automatic t_minneg();
        run_a(8'h80, 8'h10, "R8 most negative dividend", 1'b0);
        run_a(8'h10, 8'h80, "R8 most negative divisor", 1'b0);
    endtask

    task automatic t_busy_ignore();
        run_a(8'h31, 8'h17, "R7 start during busy ignored", 1'b1);
    endtask

    task automatic t_hold();
        logic [NA-1:0] held;
        held = quo_a;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(quo_a == held && done_a == 0, "R9 result held", quo_a, held);
        end
    endtask

    task automatic t_sweep();
        logic [7:0] x;
        x = 8'h5A;
        for (int k = 0; k < 12; k++) begin
            x = x * 8'd29 + 8'd71;
            run_a(x, x ^ 8'h93, "R3 sweep", 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_examples();
        t_signs();
        t_trunc();
        t_overflow();
        t_zero();
        t_minneg();
        t_busy_ignore();
        t_hold();
        t_sweep();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule